// File: doc/BRIEF.md
# Programmed I/O Command Sequencer with Single-Level Interrupt Control

This block sits between a 12-bit processor core and a shared programmed-I/O bus. The core hands it one I/O instruction word together with the current accumulator. The block splits the low nine bits into a device address and three pulse enables. It drives the address onto the bus and fires the enabled command pulses one at a time in a fixed order. During those pulses it samples the shared skip line, loads input data into a working accumulator, or presents the accumulator as output data. It then returns the new accumulator value and a skip indication to the core.

Instructions enter on a valid/ready stream. A word is taken on a clock edge where `ins_valid` and `ins_ready` are both high. `ins_ready` stays low from then until the result has been consumed. The result leaves on a second valid/ready stream. `res_valid` and its fields stay constant until an edge where `res_ready` is high, so the core can apply back-pressure for as long as it needs.

The same block owns the single-level interrupt enable. An I/O word addressed to the internal select code 0 with only the first pulse enabled (octal 6001) arms the enable. Arming takes effect one instruction later, so a return jump placed after it finishes first. At each instruction boundary that the core signals, a pending request on the shared interrupt line is taken if the enable is active. Taking it clears the enable and tells the core to perform a subroutine jump to location 0.

Top module: `iot_sequencer`

## Requirements
- R1: After reset, `ins_ready` is 1, `res_valid` is 0, no command pulse is high, `dev_sel` is 0, `irq_take` is 0 and `int_enabled` is 0.
- R2: A word is an I/O instruction only when bits 11:9 equal 6. Any other word completes with `res_skip`=0 and `res_load`=0, returns `acc_in` unchanged, and produces no pulse.
- R3: The enables are word bits 0, 1 and 2, for `cmd_p1`, `cmd_p2` and `cmd_p4`. Only enabled pulses are issued, each exactly one clock wide. They come in the order p1, p2, p4, and an idle clock with no pulse precedes every pulse.
- R4: While a pulse is high, `dev_sel` equals word bits 8:3, and it is the same value it had in the preceding clock.
- R5: `res_skip` is the value of `bus_skip` during the p1 pulse, and 0 when p1 is not enabled.
- R6: When p2 is enabled, `res_acc` is `bus_din` sampled during p2 and `res_load` is 1. Otherwise `res_acc` is `acc_in` and `res_load` is 0.
- R7: During p4, `bus_dout` carries the working accumulator: `bus_din` if p2 ran in the same instruction, otherwise `acc_in`. At all other times `bus_dout` is 0.
- R8: Select code 0 is internal and never produces a bus pulse. The word 6001 (octal) arms the interrupt enable and returns `acc_in` with no skip.
- R9: `res_valid` and the result fields hold steady while `res_ready` is 0. `ins_ready` is 0 from acceptance until the result is consumed.
- R10: `irq_take` is high only in a clock where `insn_end` and `irq_in` are both high and the enable is active. Once taken, `int_enabled` is 0.
- R11: After 6001, the first `insn_end` cannot take an interrupt; the second can. If the second boundary takes no interrupt, `int_enabled` becomes 1 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction word offered |
| ins_ready | output | 1 | Block can accept an instruction |
| ins_word | input | 12 | Instruction word |
| acc_in | input | 12 | Accumulator value at issue |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Core consumes the result |
| res_skip | output | 1 | Program counter should skip one word |
| res_load | output | 1 | Accumulator was loaded from the bus |
| res_acc | output | 12 | New accumulator value |
| dev_sel | output | 6 | Device address on the bus |
| cmd_p1 | output | 1 | First command pulse (skip test) |
| cmd_p2 | output | 1 | Second command pulse (input) |
| cmd_p4 | output | 1 | Third command pulse (output) |
| bus_dout | output | 12 | Output data to the device |
| bus_din | input | 12 | Wired-OR input data from devices |
| bus_skip | input | 1 | Wired-OR skip line |
| irq_in | input | 1 | Wired-OR interrupt request |
| insn_end | input | 1 | Core marks an instruction boundary |
| irq_take | output | 1 | Interrupt accepted; core jumps to subroutine at 0 |
| int_enabled | output | 1 | Interrupt enable is active |

## Verification
The pulse sequencer is driven with each single enable, with pairs that skip a middle or leading slot, with all three, and with none. This separates ordering mistakes from slot-skipping mistakes. Skip is tried with both line levels, so a stuck or unsampled skip shows up. Combining p2 with p4 shows whether output data follows the freshly loaded accumulator or the issue-time one. A non-I/O opcode and the internal select code confirm that neither touches the bus. The interrupt sequence raises the request before arming, at the first boundary, at the second boundary, and without a boundary, which pins down the one-instruction arming delay.

// File: rtl/iot_pkg.sv
package iot_pkg;
  localparam int WORD_W = 12;
  localparam int OP_W   = 3;
  localparam int SEL_W  = 6;
  localparam int NPULSE = 3;
  localparam int IOT_OP = 6;
  // slot positions inside the enable field; slot order is issue order
  localparam int P_SKIP = 0;
  localparam int P_IN   = 1;
  localparam int P_OUT  = 2;

  typedef enum logic [1:0] {SQ_IDLE, SQ_GAP, SQ_PULSE, SQ_RES} seq_state_t;
  typedef enum logic [1:0] {IE_OFF, IE_ARM1, IE_ARM2, IE_ON} ie_state_t;
endpackage

// File: rtl/iot_decode.sv
module iot_decode #(
  parameter int WORD_W = iot_pkg::WORD_W,
  parameter int OP_W   = iot_pkg::OP_W,
  parameter int SEL_W  = iot_pkg::SEL_W,
  parameter int NPULSE = iot_pkg::NPULSE,
  parameter int IOT_OP = iot_pkg::IOT_OP
) (
  input  logic [WORD_W-1:0] word,
  output logic [SEL_W-1:0]  sel,
  output logic [NPULSE-1:0] bus_mask,
  output logic              ion
);
  localparam int SEL_LSB = NPULSE;
  localparam int OP_LSB  = NPULSE + SEL_W;

  logic              is_iot;
  logic [NPULSE-1:0] en;

  always_comb begin
    is_iot   = (word[OP_LSB +: OP_W] == OP_W'(IOT_OP));
    sel      = word[SEL_LSB +: SEL_W];
    en       = word[NPULSE-1:0];
    // select 0 addresses the processor itself: nothing goes on the bus
    bus_mask = (is_iot && sel != '0) ? en : '0;
    ion      = is_iot && (sel == '0) && (en == NPULSE'(1));
  end
endmodule

// File: rtl/iot_pulse_seq.sv
module iot_pulse_seq #(
  parameter int W      = iot_pkg::WORD_W,
  parameter int SEL_W  = iot_pkg::SEL_W,
  parameter int NPULSE = iot_pkg::NPULSE,
  parameter int P_SKIP = iot_pkg::P_SKIP,
  parameter int P_IN   = iot_pkg::P_IN,
  parameter int P_OUT  = iot_pkg::P_OUT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEL_W-1:0]  sel,
  input  logic [NPULSE-1:0] mask,
  input  logic [W-1:0]      acc,
  input  logic [W-1:0]      bus_din,
  input  logic              bus_skip,
  input  logic              res_ready,
  output logic              idle,
  output logic [NPULSE-1:0] pulses,
  output logic [SEL_W-1:0]  dev_sel,
  output logic [W-1:0]      bus_dout,
  output logic              res_valid,
  output logic              res_skip,
  output logic              res_load,
  output logic [W-1:0]      res_acc
);
  import iot_pkg::*;

  seq_state_t        state;
  logic [NPULSE-1:0] rem_r, cur_r, low, left;
  logic [SEL_W-1:0]  sel_r;
  logic [W-1:0]      acc_w;
  logic              skip_r, load_r;

  // lowest still-pending slot, and what remains after the current one
  assign low  = rem_r & (~rem_r + {{(NPULSE-1){1'b0}}, 1'b1});
  assign left = rem_r & ~cur_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      rem_r  <= '0;
      cur_r  <= '0;
      sel_r  <= '0;
      acc_w  <= '0;
      skip_r <= 1'b0;
      load_r <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          sel_r  <= sel;
          rem_r  <= mask;
          acc_w  <= acc;
          skip_r <= 1'b0;
          load_r <= 1'b0;
          state  <= (mask != '0) ? SQ_GAP : SQ_RES;
        end
        SQ_GAP: begin
          cur_r <= low;
          state <= SQ_PULSE;
        end
        SQ_PULSE: begin
          if (cur_r[P_SKIP]) skip_r <= bus_skip;
          if (cur_r[P_IN]) begin
            acc_w  <= bus_din;
            load_r <= 1'b1;
          end
          rem_r <= left;
          state <= (left != '0) ? SQ_GAP : SQ_RES;
        end
        SQ_RES: if (res_ready) state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    idle      = (state == SQ_IDLE);
    pulses    = (state == SQ_PULSE) ? cur_r : '0;
    dev_sel   = (state == SQ_GAP || state == SQ_PULSE) ? sel_r : '0;
    bus_dout  = (state == SQ_PULSE && cur_r[P_OUT]) ? acc_w : '0;
    res_valid = (state == SQ_RES);
    res_skip  = skip_r;
    res_load  = load_r;
    res_acc   = acc_w;
  end
endmodule

// File: rtl/iot_irq_ctl.sv
module iot_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ion,
  input  logic insn_end,
  input  logic irq_in,
  output logic irq_take,
  output logic int_enabled
);
  import iot_pkg::*;

  ie_state_t st;
  logic      live;

  // the second boundary after arming already counts as enabled
  assign live        = (st == IE_ON) || (st == IE_ARM2);
  assign irq_take    = insn_end && irq_in && live;
  assign int_enabled = (st == IE_ON);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IE_OFF;
    end else if (insn_end) begin
      if (irq_take)           st <= IE_OFF;
      else if (st == IE_ARM1) st <= IE_ARM2;
      else if (st == IE_ARM2) st <= IE_ON;
    end else if (ion && st != IE_ON) begin
      st <= IE_ARM1;
    end
  end
endmodule

// File: rtl/iot_sequencer.sv
module iot_sequencer #(
  parameter int WORD_W = iot_pkg::WORD_W,
  parameter int SEL_W  = iot_pkg::SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [WORD_W-1:0] ins_word,
  input  logic [WORD_W-1:0] acc_in,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_skip,
  output logic              res_load,
  output logic [WORD_W-1:0] res_acc,
  output logic [SEL_W-1:0]  dev_sel,
  output logic              cmd_p1,
  output logic              cmd_p2,
  output logic              cmd_p4,
  output logic [WORD_W-1:0] bus_dout,
  input  logic [WORD_W-1:0] bus_din,
  input  logic              bus_skip,
  input  logic              irq_in,
  input  logic              insn_end,
  output logic              irq_take,
  output logic              int_enabled
);
  import iot_pkg::*;
  localparam int NP = NPULSE;

  logic [SEL_W-1:0] d_sel;
  logic [NP-1:0]    d_mask, pulses;
  logic             d_ion, accept, idle;

  assign accept    = ins_valid && idle;
  assign ins_ready = idle;
  assign cmd_p1    = pulses[P_SKIP];
  assign cmd_p2    = pulses[P_IN];
  assign cmd_p4    = pulses[P_OUT];

  iot_decode #(.WORD_W(WORD_W), .OP_W(OP_W), .SEL_W(SEL_W), .NPULSE(NP), .IOT_OP(IOT_OP)) u_dec (
    .word(ins_word), .sel(d_sel), .bus_mask(d_mask), .ion(d_ion));

  iot_pulse_seq #(.W(WORD_W), .SEL_W(SEL_W), .NPULSE(NP),
                  .P_SKIP(P_SKIP), .P_IN(P_IN), .P_OUT(P_OUT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .sel(d_sel), .mask(d_mask),
    .acc(acc_in), .bus_din(bus_din), .bus_skip(bus_skip), .res_ready(res_ready),
    .idle(idle), .pulses(pulses), .dev_sel(dev_sel), .bus_dout(bus_dout),
    .res_valid(res_valid), .res_skip(res_skip), .res_load(res_load), .res_acc(res_acc));

  iot_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_n), .ion(accept && d_ion), .insn_end(insn_end),
    .irq_in(irq_in), .irq_take(irq_take), .int_enabled(int_enabled));
endmodule

// File: rtl/iot_sequencer_chk.sv
module iot_sequencer_chk #(
  parameter int WORD_W = 12,
  parameter int SEL_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_skip,
  input logic              res_load,
  input logic [WORD_W-1:0] res_acc,
  input logic [SEL_W-1:0]  dev_sel,
  input logic              cmd_p1,
  input logic              cmd_p2,
  input logic              cmd_p4,
  input logic              irq_in,
  input logic              insn_end,
  input logic              irq_take,
  input logic              int_enabled
);
  logic any_p;
  assign any_p = cmd_p1 | cmd_p2 | cmd_p4;

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_p1, cmd_p2, cmd_p4}));
  p_gap_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
    any_p |=> !any_p);
  p_sel_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_p |-> $stable(dev_sel));
  p_sel0_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_sel == '0) |-> !any_p);
  p_res_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_acc) && $stable(res_skip) && $stable(res_load)));
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || any_p) |-> !ins_ready);
  p_take_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (insn_end && irq_in));
  p_take_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !int_enabled);
endmodule

bind iot_sequencer iot_sequencer_chk #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_ready(ins_ready), .res_valid(res_valid),
  .res_ready(res_ready), .res_skip(res_skip), .res_load(res_load), .res_acc(res_acc),
  .dev_sel(dev_sel), .cmd_p1(cmd_p1), .cmd_p2(cmd_p2), .cmd_p4(cmd_p4),
  .irq_in(irq_in), .insn_end(insn_end), .irq_take(irq_take), .int_enabled(int_enabled));

// File: tb/sim_iot_sequencer.sv
`timescale 1ns/1ps
module sim_iot_sequencer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ins_valid = 1'b0, res_ready = 1'b0;
  logic [11:0] ins_word = '0, acc_in = '0, bus_din = '0;
  logic        bus_skip = 1'b0, irq_in = 1'b0, insn_end = 1'b0;
  logic        ins_ready, res_valid, res_skip, res_load, cmd_p1, cmd_p2, cmd_p4;
  logic        irq_take, int_enabled;
  logic [11:0] res_acc, bus_dout;
  logic [5:0]  dev_sel;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  iot_sequencer u0 (.*);

  typedef struct packed {
    logic [11:0] word, acc, din;
    logic        skip;
    logic [8:0]  eseq;
    logic        eskip, eload;
    logic [11:0] eacc, edout;
  } vec_t;

  // eseq: pulses issued, 3 bits each, oldest in the high digits (1,2,4)
  localparam vec_t VECS [10] = '{
    '{12'o6341, 12'o1234, 12'o0000, 1'b1, 9'o001, 1'b1, 1'b0, 12'o1234, 12'o0000},
    '{12'o6341, 12'o1234, 12'o0000, 1'b0, 9'o001, 1'b0, 1'b0, 12'o1234, 12'o0000},
    '{12'o6342, 12'o1111, 12'o7070, 1'b1, 9'o002, 1'b0, 1'b1, 12'o7070, 12'o0000},
    '{12'o6344, 12'o5252, 12'o0101, 1'b1, 9'o004, 1'b0, 1'b0, 12'o5252, 12'o5252},
    '{12'o6347, 12'o0017, 12'o4000, 1'b1, 9'o124, 1'b1, 1'b1, 12'o4000, 12'o4000},
    '{12'o6345, 12'o3333, 12'o0000, 1'b0, 9'o014, 1'b0, 1'b0, 12'o3333, 12'o3333},
    '{12'o6770, 12'o0707, 12'o1111, 1'b1, 9'o000, 1'b0, 1'b0, 12'o0707, 12'o0000},
    '{12'o6776, 12'o2222, 12'o1357, 1'b1, 9'o024, 1'b0, 1'b1, 12'o1357, 12'o1357},
    '{12'o5341, 12'o4444, 12'o7777, 1'b1, 9'o000, 1'b0, 1'b0, 12'o4444, 12'o0000},
    '{12'o6003, 12'o0055, 12'o7777, 1'b1, 9'o000, 1'b0, 1'b0, 12'o0055, 12'o0000}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_iot(input vec_t v);
    logic [8:0]  seq = '0;
    logic [11:0] dout = '0;
    bit          prev = 1'b0;
    int          guard = 0;
    @(negedge clk);
    check(ins_ready, "R9 ready before issue", ins_ready, 1);
    ins_word = v.word; acc_in = v.acc; bus_din = v.din; bus_skip = v.skip; ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
    while (!res_valid && guard < 20) begin
      guard++;
      check(!ins_ready, "R9 busy", ins_ready, 0);
      if (cmd_p1 | cmd_p2 | cmd_p4) begin
        check(!prev, "R3 idle clock before pulse", prev, 0);
        check($countones({cmd_p1, cmd_p2, cmd_p4}) == 1, "R3 one pulse", {cmd_p4, cmd_p2, cmd_p1}, 1);
        check(dev_sel == v.word[8:3], "R4 select", dev_sel, v.word[8:3]);
        seq = {seq[5:0], cmd_p4, cmd_p2, cmd_p1};
        if (cmd_p4) dout = bus_dout;
        prev = 1'b1;
      end else prev = 1'b0;
      if (!cmd_p4) check(bus_dout == 0, "R7 dout quiet", bus_dout, 0);
      @(negedge clk);
    end
    check(res_valid, "R9 result arrives", res_valid, 1);
    check(seq == v.eseq, "R3 pulse order", seq, v.eseq);
    check(res_skip == v.eskip, "R5 skip", res_skip, v.eskip);
    check(res_load == v.eload, "R6 load flag", res_load, v.eload);
    check(res_acc == v.eacc, "R6 acc", res_acc, v.eacc);
    check(dout == v.edout, "R7 output data", dout, v.edout);
    @(negedge clk);
    check(res_valid && res_acc == v.eacc && !ins_ready, "R9 held", res_acc, v.eacc);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(!res_valid && ins_ready, "R9 consumed", {res_valid, ins_ready}, 1);
  endtask

  task automatic boundary(input bit irq, input bit exp_take, input string req);
    @(negedge clk);
    irq_in = irq; insn_end = 1'b1;
    #1;
    check(irq_take == exp_take, req, irq_take, exp_take);
    @(negedge clk);
    insn_end = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ins_ready && !res_valid, "R1 handshake idle", {ins_ready, res_valid}, 2);
    check(!cmd_p1 && !cmd_p2 && !cmd_p4 && dev_sel == 0, "R1 bus quiet", dev_sel, 0);
    check(!irq_take && !int_enabled, "R1 interrupt off", {irq_take, int_enabled}, 0);

    // table: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 10; i++) run_iot(VECS[i]);

    // R10: request before arming is ignored
    boundary(1'b1, 1'b0, "R10 no take while off");
    check(!int_enabled, "R10 still off", int_enabled, 0);
    // R8 / R11: arm, first boundary blocked, second takes
    run_iot('{12'o6001, 12'o0246, 12'o7777, 1'b1, 9'o000, 1'b0, 1'b0, 12'o0246, 12'o0000});
    check(!int_enabled, "R11 not yet enabled", int_enabled, 0);
    boundary(1'b1, 1'b0, "R11 first boundary blocked");
    boundary(1'b1, 1'b1, "R11 second boundary takes");
    check(!int_enabled, "R10 enable cleared", int_enabled, 0);
    // R11: arm, two quiet boundaries leave it enabled
    run_iot('{12'o6001, 12'o0001, 12'o0000, 1'b0, 9'o000, 1'b0, 1'b0, 12'o0001, 12'o0000});
    boundary(1'b0, 1'b0, "R11 quiet boundary 1");
    boundary(1'b0, 1'b0, "R11 quiet boundary 2");
    check(int_enabled, "R11 enabled", int_enabled, 1);
    // R10: request without a boundary is not taken
    @(negedge clk);
    irq_in = 1'b1;
    #1;
    check(!irq_take, "R10 needs boundary", irq_take, 0);
    @(negedge clk);
    check(int_enabled, "R10 still enabled", int_enabled, 1);
    boundary(1'b1, 1'b1, "R10 take at boundary");
    check(!int_enabled, "R10 cleared after take", int_enabled, 0);
    boundary(1'b1, 1'b0, "R10 no second take");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule